// File: doc/BRIEF.md
# Prioritised vectored interrupt controller

This block collects five interrupt request lines and picks one winner by fixed priority. The core tells it where instruction boundaries fall with a one-cycle strobe. Arbitration happens only on that strobe. When a source is accepted, the block pulses an acknowledge output one cycle later and presents a 16-bit service address. Four sources have fixed addresses. The lowest-priority source gets its address from the requesting device, and the block raises a separate device-acknowledge line for it.

The core drives the block through a one-cycle command port with four operations: turn the global enable on, turn it off, write a mask byte, and read a status byte. The mask byte also drives a serial output pin. The status byte reports the level of a serial input pin as it was in the cycle of the read.

The highest-priority source ignores both the global enable and the masks. The global enable starts to admit requests only at the second boundary after the enable command.

Top module: `prio_vec_irq`

## Requirements
- R1: Reset has these effects. The global enable is off. All three mask bits are set (sources masked). The serial output is 0. `ack`, `ext_ack` and `irq` are 0. `vector` and `cmd_rdata` are 0. Both edge latches are empty.
- R2: Priority from highest to lowest is: `req_top`, `req_edge`, `req_hi`, `req_lo`, `req_ext`.
- R3: The fixed service addresses are 0x0024 for `req_top`, 0x003C for `req_edge`, 0x0034 for `req_hi` and 0x002C for `req_lo`.
- R4: When `req_ext` wins, `ext_ack` pulses together with `ack`. `vector` then equals the `ext_vector` value sampled at the boundary.
- R5: A rising edge on `req_top` is latched. At a boundary it is accepted if the latch is set and `req_top` is still high, whatever the enable and mask state. Acceptance empties the latch and leaves the global enable unchanged.
- R6: After an enable command, the first boundary accepts no maskable source. Maskable sources can win from the second boundary onward.
- R7: A disable command blocks maskable sources from the next cycle. Accepting any maskable source turns the global enable off.
- R8: The write-mask command uses these fields. Bit 3 = 1 loads bits 2:0 as masks: bit 0 for `req_lo`, bit 1 for `req_hi`, bit 2 for `req_edge`, with 1 meaning masked. Bit 4 = 1 empties the `req_edge` latch. Bit 6 = 1 copies bit 7 to `ser_out`.
- R9: A read command loads `cmd_rdata` on the next edge, and the value holds until the next read. The layout is: bits 2:0 masks, bit 3 global enable, bit 4 `req_lo` level, bit 5 `req_hi` level, bit 6 `req_edge` latch, bit 7 `ser_in`.
- R10: The `req_edge` latch is set on a rising edge and stays set until the source is serviced or the latch is emptied by a write-mask. If a new edge and a clear fall in the same cycle, the edge wins.
- R11: Arbitration takes place only in a cycle with `boundary` high. `ack` is high only in the cycle after such a boundary. `vector` holds its value until the next acceptance.
- R12: `irq` is high in any cycle in which some source would win at a boundary. It follows the inputs without delay.
- R13: A command issued in the same cycle as an acceptance takes precedence over that acceptance's effect on the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary | input | 1 | Instruction boundary strobe |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 enable, 1 disable, 2 write mask, 3 read status |
| cmd_data | input | 8 | Write-mask byte |
| cmd_rdata | output | 8 | Status byte |
| req_top | input | 1 | Non-maskable request |
| req_edge | input | 1 | Edge-latched maskable request |
| req_hi | input | 1 | Level maskable request, higher |
| req_lo | input | 1 | Level maskable request, lower |
| req_ext | input | 1 | Non-vectored request |
| ext_vector | input | 16 | Service address from the device |
| irq | output | 1 | Request to the core |
| ack | output | 1 | Acceptance strobe |
| ext_ack | output | 1 | Acknowledge to the non-vectored device |
| vector | output | 16 | Service address of the last winner |
| ser_out | output | 1 | Serial output bit |
| ser_in | input | 1 | Serial input bit |

## Verification
The hardest case to reach is a boundary at which a request is held back only by the enable hold-off. The bench reaches it by issuing an enable while a level source is already high and unmasked, then strobing two boundaries: the first must not accept and the second must. The collision of an edge with a latch clear, and a command in the same cycle as an acceptance, each need a cycle-aligned directed step. A long pseudo-random phase then sets boundaries, commands and request lines against each other. Throughout, a behavioural model in the bench is compared with every output on every clock.

// File: rtl/prio_vec_irq.sv
module prio_vec_irq #(
  parameter int VW = 16,
  parameter logic [VW-1:0] TOP_VEC  = 16'h0024,
  parameter logic [VW-1:0] EDGE_VEC = 16'h003C,
  parameter logic [VW-1:0] HI_VEC   = 16'h0034,
  parameter logic [VW-1:0] LO_VEC   = 16'h002C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [7:0]    cmd_data,
  output logic [7:0]    cmd_rdata,
  input  logic          req_top,
  input  logic          req_edge,
  input  logic          req_hi,
  input  logic          req_lo,
  input  logic          req_ext,
  input  logic [VW-1:0] ext_vector,
  output logic          irq,
  output logic          ack,
  output logic          ext_ack,
  output logic [VW-1:0] vector,
  output logic          ser_out,
  input  logic          ser_in
);
  localparam logic [1:0] OP_ON = 2'd0, OP_OFF = 2'd1, OP_MASK = 2'd2, OP_STAT = 2'd3;

  logic       ie, hold;
  logic [2:0] mask;
  logic       top_pend, top_q, edge_pend, edge_q;
  logic [VW-1:0] win_vec;

  wire open_gate = ie & ~hold;
  wire sel_top  = top_pend & req_top;
  wire sel_edge = open_gate & edge_pend & ~mask[2];
  wire sel_hi   = open_gate & req_hi & ~mask[1];
  wire sel_lo   = open_gate & req_lo & ~mask[0];
  wire sel_ext  = open_gate & req_ext;
  wire win_ext  = ~sel_top & ~sel_edge & ~sel_hi & ~sel_lo & sel_ext;

  assign irq = sel_top | sel_edge | sel_hi | sel_lo | sel_ext;
  wire take = boundary & irq;

  wire is_on   = cmd_valid && cmd_op == OP_ON;
  wire is_off  = cmd_valid && cmd_op == OP_OFF;
  wire is_mask = cmd_valid && cmd_op == OP_MASK;
  wire is_stat = cmd_valid && cmd_op == OP_STAT;

  always_comb begin
    if (sel_top)       win_vec = TOP_VEC;
    else if (sel_edge) win_vec = EDGE_VEC;
    else if (sel_hi)   win_vec = HI_VEC;
    else if (sel_lo)   win_vec = LO_VEC;
    else               win_vec = ext_vector;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie        <= 1'b0;
      hold      <= 1'b0;
      mask      <= 3'b111;
      top_pend  <= 1'b0;
      top_q     <= 1'b0;
      edge_pend <= 1'b0;
      edge_q    <= 1'b0;
      ack       <= 1'b0;
      ext_ack   <= 1'b0;
      vector    <= '0;
      cmd_rdata <= 8'h00;
      ser_out   <= 1'b0;
    end else begin
      ack     <= take;
      ext_ack <= take & win_ext;
      if (take) vector <= win_vec;
      if (boundary) hold <= 1'b0;
      if (take && !sel_top) ie <= 1'b0;
      if (take && sel_top) top_pend <= 1'b0;
      if (req_top && !top_q) top_pend <= 1'b1;
      top_q <= req_top;
      if ((take && !sel_top && sel_edge) || (is_mask && cmd_data[4])) edge_pend <= 1'b0;
      if (req_edge && !edge_q) edge_pend <= 1'b1;
      edge_q <= req_edge;
      if (is_on) begin
        ie   <= 1'b1;
        hold <= 1'b1;
      end
      if (is_off) begin
        ie   <= 1'b0;
        hold <= 1'b0;
      end
      if (is_mask) begin
        if (cmd_data[3]) mask <= cmd_data[2:0];
        if (cmd_data[6]) ser_out <= cmd_data[7];
      end
      if (is_stat) cmd_rdata <= {ser_in, edge_pend, req_hi, req_lo, ie, mask};
    end
  end

  p_ack_after_boundary_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(boundary));
  p_ext_vector_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ack |-> (ack && vector == $past(ext_vector)));
  p_gate_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && (ext_ack || vector != TOP_VEC) && !$past(cmd_valid)) |-> !ie);
  p_mask_respected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ext_ack && vector == HI_VEC) |-> !$past(mask[1]));
  p_holdoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && (ext_ack || vector != TOP_VEC)) |-> !$past(hold));
  p_single_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ack |-> !$past(sel_top || sel_edge || sel_hi || sel_lo));
endmodule

// File: tb/sim_prio_vec_irq.sv
module sim_prio_vec_irq;
  localparam int P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic boundary = 0, cmd_valid = 0, ser_in = 0;
  logic [1:0] cmd_op = 0;
  logic [7:0] cmd_data = 0;
  logic req_top = 0, req_edge = 0, req_hi = 0, req_lo = 0, req_ext = 0;
  logic [15:0] ext_vector = 16'h0000;
  logic [7:0] cmd_rdata;
  logic irq, ack, ext_ack, ser_out;
  logic [15:0] vector;

  int errors = 0, checks = 0;
  string tag = "R1";
  bit done = 0;

  always #(P/2) clk = ~clk;

  prio_vec_irq u0 (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_rdata(cmd_rdata),
    .req_top(req_top), .req_edge(req_edge), .req_hi(req_hi), .req_lo(req_lo),
    .req_ext(req_ext), .ext_vector(ext_vector), .irq(irq), .ack(ack),
    .ext_ack(ext_ack), .vector(vector), .ser_out(ser_out), .ser_in(ser_in)
  );

  // behavioural reference
  bit m_ie, m_hold, m_pt, m_qt, m_pe, m_qe, m_ack, m_xack, m_ser;
  bit [2:0] m_mask;
  bit [15:0] m_vec;
  bit [7:0] m_rd;

  function automatic int pick();
    if (m_pt && req_top) return 0;
    if (m_ie && !m_hold) begin
      if (m_pe && !m_mask[2]) return 1;
      if (req_hi && !m_mask[1]) return 2;
      if (req_lo && !m_mask[0]) return 3;
      if (req_ext) return 4;
    end
    return -1;
  endfunction

  function automatic bit [15:0] addr_of(int w);
    case (w)
      0: return 16'h0024;
      1: return 16'h003C;
      2: return 16'h0034;
      3: return 16'h002C;
      default: return ext_vector;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ie = 0; m_hold = 0; m_pt = 0; m_qt = 0; m_pe = 0; m_qe = 0;
      m_ack = 0; m_xack = 0; m_ser = 0; m_mask = 3'b111; m_vec = 0; m_rd = 0;
    end else begin
      int w;
      bit [7:0] snap;
      w = pick();
      snap = {ser_in, m_pe, req_hi, req_lo, m_ie, m_mask};
      m_ack = boundary && (w >= 0);
      m_xack = m_ack && (w == 4);
      if (m_ack) m_vec = addr_of(w);
      if (boundary) m_hold = 0;
      if (m_ack && w != 0) m_ie = 0;
      if (m_ack && w == 0) m_pt = 0;
      if (m_ack && w == 1) m_pe = 0;
      if (cmd_valid && cmd_op == 2 && cmd_data[4]) m_pe = 0;
      if (req_top && !m_qt) m_pt = 1;
      if (req_edge && !m_qe) m_pe = 1;
      m_qt = req_top;
      m_qe = req_edge;
      if (cmd_valid) begin
        case (cmd_op)
          2'd0: begin m_ie = 1; m_hold = 1; end
          2'd1: begin m_ie = 0; m_hold = 0; end
          2'd2: begin
            if (cmd_data[3]) m_mask = cmd_data[2:0];
            if (cmd_data[6]) m_ser = cmd_data[7];
          end
          default: m_rd = snap;
        endcase
      end
    end
  end

  task automatic chk(string what, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("ack", {15'd0, ack}, {15'd0, m_ack});
    chk("ext_ack", {15'd0, ext_ack}, {15'd0, m_xack});
    chk("vector", vector, m_vec);
    chk("status", {8'd0, cmd_rdata}, {8'd0, m_rd});
    chk("ser_out", {15'd0, ser_out}, {15'd0, m_ser});
    chk("irq", {15'd0, irq}, {15'd0, (pick() >= 0) ? 1'b1 : 1'b0});
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic cmd(logic [1:0] op, logic [7:0] d);
    cmd_valid = 1; cmd_op = op; cmd_data = d; tick();
    cmd_valid = 0;
  endtask

  task automatic bnd();
    boundary = 1; tick(); boundary = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    tag = "R1";
    tick(3);
    rst_n = 1;
    tick(2);
    cmd(2'd3, 8'h00); tick();
    chk("R1 status after reset", {8'd0, cmd_rdata}, 16'h0007);

    // R5: non-maskable source while gate is off and everything masked
    tag = "R5";
    req_top = 1; tick(); bnd(); tick();
    req_top = 0; tick(); bnd(); tick();
    req_top = 1; tick(); req_top = 0; tick(); bnd(); tick(); // edge seen but level gone

    // R8: write-mask fields
    tag = "R8";
    cmd(2'd2, 8'h0F); cmd(2'd2, 8'hC0); cmd(2'd2, 8'h40); cmd(2'd2, 8'hC0);
    cmd(2'd2, 8'h08); cmd(2'd3, 8'h00); tick();

    // R6: enable hold-off with a ready level source
    tag = "R6";
    req_lo = 1; cmd(2'd0, 8'h00); tick();
    bnd(); tick(); bnd(); tick();
    req_lo = 0;

    // R7: disable takes effect at once
    tag = "R7";
    cmd(2'd0, 8'h00); bnd(); req_hi = 1; cmd(2'd1, 8'h00); bnd(); bnd(); tick();
    req_hi = 0;

    // R2, R3, R4: all sources pending, serviced in order
    tag = "R2";
    ext_vector = 16'hBEEF;
    req_edge = 1; tick(); req_edge = 0;
    req_hi = 1; req_lo = 1; req_ext = 1; req_top = 1; tick();
    repeat (6) begin cmd(2'd0, 8'h00); bnd(); bnd(); tick(); end
    req_hi = 0; tick(); cmd(2'd0, 8'h00); bnd(); bnd();
    req_lo = 0; tick(); cmd(2'd0, 8'h00); bnd(); bnd();
    tag = "R4";
    ext_vector = 16'h1234; cmd(2'd0, 8'h00); bnd(); bnd(); tick();
    req_ext = 0; req_top = 0; tick();

    tag = "R3";
    cmd(2'd2, 8'h08);
    req_hi = 1; cmd(2'd0, 8'h00); bnd(); bnd(); req_hi = 0; tick();
    req_lo = 1; cmd(2'd0, 8'h00); bnd(); bnd(); req_lo = 0; tick();
    req_edge = 1; cmd(2'd0, 8'h00); bnd(); bnd(); req_edge = 0; tick();

    // R10: edge latch behaviour
    tag = "R10";
    cmd(2'd2, 8'h0C);
    req_edge = 1; tick(); req_edge = 0; tick(3);
    cmd(2'd3, 8'h00); tick();
    cmd(2'd2, 8'h10); cmd(2'd3, 8'h00); tick();
    req_edge = 1; cmd(2'd2, 8'h10); req_edge = 0; cmd(2'd3, 8'h00); tick();
    cmd(2'd2, 8'h08); cmd(2'd0, 8'h00); bnd(); bnd(); tick();

    // R9: status layout with serial input high
    tag = "R9";
    ser_in = 1; req_hi = 1; cmd(2'd2, 8'h0A); cmd(2'd3, 8'h00); ser_in = 0; tick(2);
    req_hi = 0;

    // R11, R12: pending request without a boundary never acknowledges
    tag = "R11";
    cmd(2'd2, 8'h08); req_lo = 1; cmd(2'd0, 8'h00); bnd(); tick(8);
    tag = "R12";
    req_lo = 0; tick(); req_lo = 1; tick(); bnd(); tick();

    // R13: command on the acceptance cycle
    tag = "R13";
    cmd(2'd0, 8'h00); bnd();
    boundary = 1; cmd(2'd0, 8'h00); boundary = 0;
    bnd(); bnd(); tick();
    req_lo = 0;

    // mixed pseudo-random traffic
    tag = "R2";
    repeat (4000) begin
      boundary = ($urandom % 3) == 0;
      req_top = ($urandom % 16) == 0;
      req_edge = ($urandom % 5) == 0;
      req_hi = ($urandom % 4) == 0;
      req_lo = ($urandom % 4) == 0;
      req_ext = ($urandom % 3) == 0;
      ser_in = $urandom;
      ext_vector = 16'($urandom);
      cmd_valid = ($urandom % 6) == 0;
      cmd_op = 2'($urandom);
      cmd_data = 8'($urandom);
      tick();
    end
    cmd_valid = 0; boundary = 0;
    tick(3);
    finish_run();
  end
endmodule